// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout and Reset Generator

This block watches software activity and produces the chip's internal reset. A single counter chain serves two purposes. After power-up it times the power-on delay. After that it acts as the watchdog timer. The chain advances on one of two sources, chosen by a mode field. The first source is a single-cycle tick from a slow on-chip oscillator. The second is every cycle of the crystal clock, which is the block's own clock. A two-bit field in the mode register picks one of four timeout taps. Two further enable bits decide whether counting goes on while the core is in HALT or STOP.

Software keeps the chip alive in one of two ways: it pulses the clear strobe, or it rewrites the mode register. Either action restarts the count. If the selected tap is reached first, the block raises its reset output for a fixed stretch of clocks and returns the mode register to its defaults. An external active-low reset pin is accepted only after it has been held for a number of consecutive clocks. While accepted, it holds the same reset output, and the stretch follows its release.

Top module: `wdg_ctrl`

## Requirements
- R1: Releasing `por_n` starts the power-on phase. During this phase `rst_out` stays 1 until `POR_TICKS` (5) oscillator ticks have been counted, and then for 18 more clocks. During power-on reset `mode_q` reads 5'b01100.
- R2: The mode bits are: [1:0] tap code, [2] HALT enable, [3] STOP enable, [4] source (1 = crystal). With source 1, tap codes 00, 01, 10 and 11 raise `rst_out` on the 256th, 512th, 1024th and 4096th clock after the accepted write.
- R3: With source 0, the same codes raise `rst_out` on the 5th, 15th, 25th and 100th oscillator tick after the write, whatever the spacing of the ticks.
- R4: Every timeout holds `rst_out` at 1 for exactly 18 clocks.
- R5: A watchdog timeout returns `mode_q` to 5'b01100.
- R6: A `wdt_clr` pulse zeroes the count. A clear in the same cycle as the final tick prevents the timeout, and a full new period follows.
- R7: An accepted mode write restarts the count from zero.
- R8: While `halt_i` is 1 and mode bit 2 is 0, the count is frozen and keeps its value. With bit 2 set, counting continues in HALT.
- R9: While `stop_i` is 1, the crystal source never counts. The oscillator source counts only if mode bit 3 is 1.
- R10: `ext_rst_n` held low for fewer than 4 consecutive clocks has no effect. Held for 4 or more, it raises `rst_out` on the 5th clock, keeps it high while held, and keeps it high for 18 clocks after the first high sample. The accepted external reset also restores mode 5'b01100.
- R11: While `rst_out` is 1, mode writes and clear pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| halt_i | input | 1 | Core is in HALT |
| stop_i | input | 1 | Core is in STOP |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_clr | input | 1 | Software clear strobe |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 5 | Mode register write value |
| mode_q | output | 5 | Current mode register |
| rst_out | output | 1 | Internal reset, active high |

## Verification
A wrong count, tap or gating decision shows up as an early or late rising edge on `rst_out`. The bench measures that edge in exact clocks or ticks from the restarting write. A corrupted stretch counter changes the pulse length, which is checked on every timeout. A mode register that fails to reset is visible on `mode_q` in the first idle cycle after the pulse ends. A filter fault moves the external reset edge by one or more clocks, or lets a three-clock glitch through; either shows within five clocks.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef struct packed {
      logic       src;      // 1: crystal clock, 0: oscillator tick
      logic       stop_en;  // count while in STOP
      logic       halt_en;  // count while in HALT
      logic [1:0] tap;      // timeout tap code
   } wdg_mode_t;

   localparam wdg_mode_t MODE_RST = '{src: 1'b0, stop_en: 1'b1, halt_en: 1'b1, tap: 2'b00};

   localparam int NUM_TAPS = 4;

endpackage

// File: rtl/wdg_rst_filter.sv
module wdg_rst_filter #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic ext_n,
   output logic active
);

   if (HOLD < 2) begin : g_bad_hold
      $error("wdg_rst_filter: HOLD must be at least 2");
   end

   logic [HOLD-1:0] low_hist;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) low_hist <= '0;
      else        low_hist <= {low_hist[HOLD-2:0], ~ext_n};
   end

   assign active = &low_hist;

   // the filter may only report a held pin if the latest sample was low
   p_glitch_r10: assert property (@(posedge clk) disable iff (!por_n)
      active |-> $past(~ext_n));

endmodule

// File: rtl/wdg_chain.sv
module wdg_chain
   import wdg_pkg::*;
#(
   parameter int CW        = 16,
   parameter int XT0       = 256,
   parameter int XT1       = 512,
   parameter int XT2       = 1024,
   parameter int XT3       = 4096,
   parameter int RC0       = 5,
   parameter int RC1       = 15,
   parameter int RC2       = 25,
   parameter int RC3       = 100,
   parameter int POR_TICKS = 5
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       tick,
   input  logic       clear,
   input  logic       use_por,
   input  logic       src,
   input  logic [1:0] tap,
   output logic       hit
);

   localparam int XT_TAB [NUM_TAPS] = '{XT0, XT1, XT2, XT3};
   localparam int RC_TAB [NUM_TAPS] = '{RC0, RC1, RC2, RC3};
   localparam logic [CW-1:0] ONE = 1;

   if (CW < 2 || CW > 31) begin : g_bad_cw
      $error("wdg_chain: CW out of range");
   end
   if (POR_TICKS < 1 || POR_TICKS >= (1 << CW)) begin : g_bad_por
      $error("wdg_chain: POR_TICKS does not fit");
   end

   logic [CW-1:0] lim_xt [NUM_TAPS];
   logic [CW-1:0] lim_rc [NUM_TAPS];

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      if (XT_TAB[i] < 1 || XT_TAB[i] >= (1 << CW)) begin : g_bad_xt
         $error("wdg_chain: crystal tap does not fit");
      end
      if (RC_TAB[i] < 1 || RC_TAB[i] >= (1 << CW)) begin : g_bad_rc
         $error("wdg_chain: oscillator tap does not fit");
      end
      assign lim_xt[i] = CW'(XT_TAB[i]);
      assign lim_rc[i] = CW'(RC_TAB[i]);
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   always_comb begin
      if (use_por)  limit = CW'(POR_TICKS);
      else if (src) limit = lim_xt[tap];
      else          limit = lim_rc[tap];
   end

   assign hit = tick & ~clear & (cnt == limit - ONE);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           cnt <= '0;
      else if (clear | hit) cnt <= '0;
      else if (tick)        cnt <= cnt + ONE;
   end

   p_bound_r3: assert property (@(posedge clk) disable iff (!por_n)
      cnt < limit);
   p_freeze_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!tick && !clear) |=> $stable(cnt));
   p_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
   parameter int STRETCH = 18
) (
   input  logic clk,
   input  logic por_n,
   input  logic load,
   input  logic por_done,
   output logic por_busy,
   output logic rst_out
);

   localparam int SW = $clog2(STRETCH + 1);
   localparam logic [SW-1:0] S_LOAD = SW'(STRETCH);
   localparam logic [SW-1:0] S_ONE  = 1;

   if (STRETCH < 1) begin : g_bad_stretch
      $error("wdg_pulse: STRETCH must be positive");
   end

   logic [SW-1:0] remain;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            remain <= '0;
      else if (load)         remain <= S_LOAD;
      else if (remain != '0) remain <= remain - S_ONE;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        por_busy <= 1'b1;
      else if (por_done) por_busy <= 1'b0;
   end

   assign rst_out = por_busy | (remain != '0);

   p_load_r4: assert property (@(posedge clk) disable iff (!por_n)
      load |=> (rst_out && remain == S_LOAD));
   p_por_end_r1: assert property (@(posedge clk) disable iff (!por_n)
      $fell(por_busy) |-> (remain == S_LOAD));

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
   import wdg_pkg::*;
#(
   parameter int CW        = 16,
   parameter int XT0       = 256,
   parameter int XT1       = 512,
   parameter int XT2       = 1024,
   parameter int XT3       = 4096,
   parameter int RC0       = 5,
   parameter int RC1       = 15,
   parameter int RC2       = 25,
   parameter int RC3       = 100,
   parameter int POR_TICKS = 5,
   parameter int STRETCH   = 18,
   parameter int HOLD      = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       osc_tick,
   input  logic       halt_i,
   input  logic       stop_i,
   input  logic       ext_rst_n,
   input  logic       wdt_clr,
   input  logic       mode_we,
   input  logic [4:0] mode_wdata,
   output logic [4:0] mode_q,
   output logic       rst_out
);

   wdg_mode_t mode;
   logic ext_act, por_busy, hit;
   logic clr_ok, we_ok, low_ok, tick, chain_clr;
   logic por_done, wdt_to, load;

   wdg_rst_filter #(.HOLD(HOLD)) u_filt (
      .clk    (clk),
      .por_n  (por_n),
      .ext_n  (ext_rst_n),
      .active (ext_act)
   );

   assign clr_ok = wdt_clr & ~rst_out;
   assign we_ok  = mode_we & ~rst_out;
   assign low_ok = (~halt_i | mode.halt_en) & (~stop_i | mode.stop_en);

   always_comb begin
      if (por_busy)      tick = osc_tick;
      else if (mode.src) tick = ~stop_i & low_ok;
      else               tick = osc_tick & low_ok;
   end

   assign chain_clr = (rst_out & ~por_busy) | clr_ok | we_ok | ext_act;

   wdg_chain #(
      .CW(CW), .XT0(XT0), .XT1(XT1), .XT2(XT2), .XT3(XT3),
      .RC0(RC0), .RC1(RC1), .RC2(RC2), .RC3(RC3), .POR_TICKS(POR_TICKS)
   ) u_chain (
      .clk     (clk),
      .por_n   (por_n),
      .tick    (tick),
      .clear   (chain_clr),
      .use_por (por_busy),
      .src     (mode.src),
      .tap     (mode.tap),
      .hit     (hit)
   );

   assign por_done = hit & por_busy;
   assign wdt_to   = hit & ~por_busy;
   assign load     = por_done | wdt_to | ext_act;

   wdg_pulse #(.STRETCH(STRETCH)) u_pulse (
      .clk      (clk),
      .por_n    (por_n),
      .load     (load),
      .por_done (por_done),
      .por_busy (por_busy),
      .rst_out  (rst_out)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                mode <= MODE_RST;
      else if (wdt_to | ext_act) mode <= MODE_RST;
      else if (we_ok)            mode <= wdg_mode_t'(mode_wdata);
   end

   assign mode_q = mode;

   p_mode_dflt_r5: assert property (@(posedge clk) disable iff (!por_n)
      wdt_to |=> (mode_q == MODE_RST));
   p_wr_ignored_r11: assert property (@(posedge clk) disable iff (!por_n)
      (rst_out && !load) |=> $stable(mode_q));

endmodule

// File: tb/sim_wdg_ctrl.sv
`timescale 1ns/1ps
module sim_wdg_ctrl;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       halt_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic       wdt_clr = 1'b0;
   logic       mode_we = 1'b0;
   logic [4:0] mode_wdata = '0;
   logic [4:0] mode_q;
   logic       rst_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   localparam logic [4:0] DFLT = 5'b01100;
   localparam int XT [4] = '{256, 512, 1024, 4096};
   localparam int RC [4] = '{5, 15, 25, 100};

   always #2.5 clk = ~clk;

   wdg_ctrl u0 (
      .clk(clk), .por_n(por_n), .osc_tick(osc_tick), .halt_i(halt_i),
      .stop_i(stop_i), .ext_rst_n(ext_rst_n), .wdt_clr(wdt_clr),
      .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
      .rst_out(rst_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [4:0] v);
      mode_we = 1'b1; mode_wdata = v; osc_tick = 1'b0;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic ticks(input int k);
      repeat (k) begin
         osc_tick = 1'b1; @(negedge clk);
         osc_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic run_until(input int per, input bit all, input int maxc, output int n);
      int ph = 0;
      n = 0;
      for (int c = 0; c < maxc; c++) begin
         osc_tick = (ph == per - 1);
         ph = (ph + 1) % per;
         if (all || osc_tick) n++;
         @(negedge clk);
         if (rst_out) begin
            osc_tick = 1'b0;
            return;
         end
      end
      osc_tick = 1'b0;
      n = -1;
   endtask

   task automatic high_len(output int h);
      h = 0;
      osc_tick = 1'b0;
      while (rst_out && h < 1000) begin
         @(negedge clk);
         h++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n, h, z;
      bit seen;
      // R1: power-on phase
      repeat (3) @(negedge clk);
      chk(rst_out == 1'b1, "R1 reset out during por", rst_out, 1);
      chk(mode_q == DFLT, "R1 mode default", mode_q, DFLT);
      por_n = 1'b1;
      ticks(4);
      repeat (40) @(negedge clk);
      chk(rst_out == 1'b1, "R1 held before last tick", rst_out, 1);
      osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
      high_len(h);
      chk(h == 18, "R1 stretch after por tap", h, 18);

      // R2: crystal taps, R4 pulse, R5 mode return
      for (int c = 0; c < 4; c++) begin
         do_write({3'b111, 2'(c)});
         run_until(1, 1'b1, 6000, n);
         chk(n == XT[c], "R2 crystal timeout", n, XT[c]);
         high_len(h);
         chk(h == 18, "R4 pulse length", h, 18);
         chk(mode_q == DFLT, "R5 mode after timeout", mode_q, DFLT);
      end

      // R3: oscillator taps with several tick spacings
      for (int p = 1; p <= 3; p++) begin
         for (int c = 0; c < 4; c++) begin
            do_write({3'b011, 2'(c)});
            run_until(p, 1'b0, 400, n);
            chk(n == RC[c], "R3 oscillator timeout", n, RC[c]);
            high_len(h);
            chk(h == 18, "R4 pulse length osc", h, 18);
         end
      end

      // R6: clear strobe
      do_write(DFLT);
      ticks(3);
      wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
      run_until(2, 1'b0, 100, n);
      chk(n == 5, "R6 clear restarts", n, 5);
      high_len(h);
      do_write(DFLT);
      ticks(4);
      wdt_clr = 1'b1; osc_tick = 1'b1; @(negedge clk);
      wdt_clr = 1'b0; osc_tick = 1'b0;
      chk(rst_out == 1'b0, "R6 clear beats final tick", rst_out, 0);
      run_until(2, 1'b0, 100, n);
      chk(n == 5, "R6 full period after clear", n, 5);
      high_len(h);

      // R7: rewrite restarts
      do_write(5'b11100);
      repeat (200) @(negedge clk);
      do_write(5'b11100);
      run_until(1, 1'b1, 1000, n);
      chk(n == 256, "R7 write restarts count", n, 256);
      high_len(h);

      // R8: HALT gating
      do_write(5'b01000);
      ticks(3);
      halt_i = 1'b1;
      ticks(20);
      chk(rst_out == 1'b0, "R8 frozen in halt", rst_out, 0);
      halt_i = 1'b0;
      run_until(2, 1'b0, 100, n);
      chk(n == 2, "R8 count kept through halt", n, 2);
      high_len(h);
      halt_i = 1'b1;
      do_write(DFLT);
      run_until(2, 1'b0, 100, n);
      chk(n == 5, "R8 counts in halt when enabled", n, 5);
      high_len(h);
      do_write(5'b11000);
      run_until(1, 1'b1, 300, n);
      chk(n == -1, "R8 crystal frozen in halt", n, -1);
      halt_i = 1'b0;
      run_until(1, 1'b1, 1000, n);
      chk(n == 256, "R8 crystal resumes", n, 256);
      high_len(h);

      // R9: STOP gating
      stop_i = 1'b1;
      do_write(5'b00100);
      ticks(20);
      chk(rst_out == 1'b0, "R9 osc frozen in stop", rst_out, 0);
      do_write(DFLT);
      run_until(2, 1'b0, 100, n);
      chk(n == 5, "R9 osc counts in stop", n, 5);
      high_len(h);
      do_write(5'b11100);
      run_until(1, 1'b1, 300, n);
      chk(n == -1, "R9 crystal never counts in stop", n, -1);
      stop_i = 1'b0;
      run_until(1, 1'b1, 1000, n);
      chk(n == 256, "R9 crystal after stop", n, 256);
      high_len(h);

      // R11: writes and clears ignored during reset
      do_write(DFLT);
      run_until(1, 1'b0, 100, n);
      mode_we = 1'b1; mode_wdata = 5'b11011; wdt_clr = 1'b1;
      @(negedge clk);
      mode_we = 1'b0; wdt_clr = 1'b0;
      high_len(h);
      chk(h == 17, "R11 pulse unaffected", h, 17);
      chk(mode_q == DFLT, "R11 write ignored", mode_q, DFLT);
      run_until(1, 1'b0, 100, n);
      chk(n == 5, "R11 default tap after", n, 5);
      high_len(h);

      // R10: external reset filter
      do_write(5'b11011);
      ext_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      ext_rst_n = 1'b1;
      seen = 1'b0;
      repeat (10) begin
         @(negedge clk);
         if (rst_out) seen = 1'b1;
      end
      chk(!seen, "R10 short glitch ignored", seen, 0);
      chk(mode_q == 5'b11011, "R10 mode kept after glitch", mode_q, 5'b11011);
      ext_rst_n = 1'b0;
      z = 0;
      while (z < 20) begin
         @(negedge clk);
         if (rst_out) break;
         z++;
      end
      chk(z == 4, "R10 accept after hold", z, 4);
      repeat (6) @(negedge clk);
      chk(rst_out == 1'b1, "R10 held while low", rst_out, 1);
      ext_rst_n = 1'b1;
      @(negedge clk);
      high_len(h);
      chk(h == 18, "R10 stretch after release", h, 18);
      chk(mode_q == DFLT, "R10 mode default", mode_q, DFLT);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule